// File: doc/BRIEF.md
# Bulk pin configuration writer

This block holds the per-pin configuration of a 32-pin group and drives the resulting enables and multiplexer selections to the pad logic. Each pin has a configuration byte and a 4-bit peripheral-multiplexer selection. Each configuration byte holds four flags: multiplexer enable, input enable, pull enable and drive strength. Software can reach these through ordinary byte accesses: one configuration byte per pin, and one multiplexer byte per pair of pins.

The block also accepts a write-only bulk word. A single bulk write updates any subset of one half of the group in one bus cycle. The subset is chosen by a 16-bit mask and a half select. Two separate write-enable bits decide whether the configuration flags, the multiplexer selection, both or neither are written to the selected pins.

All writes land on the clock edge that accepts them. Reads are registered and return one cycle after the request. Mapped offsets: bulk word 0x28, multiplexer bytes 0x30..0x3F, configuration bytes 0x40..0x5F.

Top module: `bulk_pincfg`

## Requirements
- R1: After reset every configuration byte and multiplexer selection is zero, so all pad outputs are low.
- R2: A write to offset 0x28 with bit 30 set loads the configuration flags of every selected pin: bit 16 into multiplexer enable, bit 17 into input enable, bit 18 into pull enable, bit 22 into drive strength.
- R3: In a bulk write, bit 31 chooses the half. When it is 0, mask bit i (i = 0..15, from bits 15..0) selects pin i. When it is 1, mask bit i selects pin 16+i. Pins in the other half, and pins whose mask bit is 0, keep their state.
- R4: A bulk write with bit 28 set loads bits 27..24 into the 4-bit multiplexer selection of every selected pin.
- R5: A bulk write with bit 30 clear leaves the configuration flags of all pins unchanged. A bulk write with bit 28 clear leaves all multiplexer selections unchanged. Both hold even when mask bits are set.
- R6: A byte write to offset 0x30+k loads data bits 3..0 into the selection of pin 2k and bits 7..4 into the selection of pin 2k+1. A read of 0x30+k returns that byte in rdata bits 7..0.
- R7: A byte write to offset 0x40+p stores data bits 0 (multiplexer enable), 1 (input enable), 2 (pull enable) and 6 (drive strength) for pin p and drops all other bits. A read returns the stored byte, which is the written value ANDed with 0x47.
- R8: Reading offset 0x28, or any unmapped offset, returns zero.
- R9: Read data appears on rdata in the cycle after rd_en is sampled, and is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, sampled on the rising edge |
| rd_en | input | 1 | Read request, sampled on the rising edge |
| addr | input | ADDR_W (7) | Byte offset of the access |
| wdata | input | 32 | Write data; byte writes use bits 7..0 |
| rdata | output | 32 | Registered read data |
| mux_en | output | NUM_PINS (32) | Per-pin peripheral multiplexer enable |
| in_en | output | NUM_PINS (32) | Per-pin input enable |
| pull_en | output | NUM_PINS (32) | Per-pin pull enable |
| drv_str | output | NUM_PINS (32) | Per-pin drive strength select |
| mux_sel | output | NUM_PINS*4 (128) | Per-pin multiplexer selection, pin p at bits 4p+3..4p |

## Verification
Writes of any kind change the pad outputs one edge after the write is sampled. The bench therefore drives a write at a falling edge, releases it at the next falling edge, and compares all five pad vectors against its model at that same falling edge. Reads return on rdata one edge after rd_en is sampled. The driver queues the expected read value when it issues the request, and the monitor compares it at the falling edge that follows the edge on which the read was taken, so each comparison lands exactly where its result becomes valid.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    localparam int SEL_W = 4;

    // Bulk word field positions (decoded by the per-pin update logic)
    localparam int BK_HALF    = 31;
    localparam int BK_WR_CFG  = 30;
    localparam int BK_WR_SEL  = 28;
    localparam int BK_SEL_LSB = 24;
    localparam int BK_DRV     = 22;
    localparam int BK_PULL    = 18;
    localparam int BK_INEN    = 17;
    localparam int BK_MUXEN   = 16;

    // Configuration byte positions
    localparam int CB_MUXEN = 0;
    localparam int CB_INEN  = 1;
    localparam int CB_PULL  = 2;
    localparam int CB_DRV   = 6;

    typedef struct packed {
        logic drv;
        logic pull;
        logic inen;
        logic muxen;
    } pin_cfg_t;

    function automatic logic [7:0] cfg_to_byte(pin_cfg_t c);
        logic [7:0] b;
        b = '0;
        b[CB_MUXEN] = c.muxen;
        b[CB_INEN]  = c.inen;
        b[CB_PULL]  = c.pull;
        b[CB_DRV]   = c.drv;
        return b;
    endfunction
endpackage

// File: rtl/bpc_decode.sv
module bpc_decode
    import bpc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 7,
    parameter int BULK_OFS = 'h28,
    parameter int MUX_OFS  = 'h30,
    parameter int CFG_OFS  = 'h40
) (
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [31:0]                      wdata,
    output logic [NUM_PINS-1:0]              cfg_we,
    output pin_cfg_t [NUM_PINS-1:0]          cfg_wval,
    output logic [NUM_PINS-1:0]              sel_we,
    output logic [NUM_PINS-1:0][SEL_W-1:0]   sel_wval
);
    localparam int HALF_W = NUM_PINS / 2;

    logic     bulk_hit;
    pin_cfg_t bulk_cfg;
    logic     unused_wdata;

    assign bulk_hit = wr_en && (addr == ADDR_W'(BULK_OFS));
    assign bulk_cfg = pin_cfg_t'({wdata[BK_DRV], wdata[BK_PULL],
                                  wdata[BK_INEN], wdata[BK_MUXEN]});
    assign unused_wdata = ^{wdata[29], wdata[23], wdata[21:19]};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int HALF = p / HALF_W;
        localparam int IDX  = p % HALF_W;
        localparam int LANE = (p % 2) * SEL_W;

        logic picked, cfg_byte_hit, mux_byte_hit;

        assign picked       = bulk_hit && (wdata[BK_HALF] == 1'(HALF)) && wdata[IDX];
        assign cfg_byte_hit = wr_en && (addr == ADDR_W'(CFG_OFS + p));
        assign mux_byte_hit = wr_en && (addr == ADDR_W'(MUX_OFS + p / 2));

        always_comb begin
            cfg_we[p]   = (picked && wdata[BK_WR_CFG]) || cfg_byte_hit;
            sel_we[p]   = (picked && wdata[BK_WR_SEL]) || mux_byte_hit;
            cfg_wval[p] = cfg_byte_hit
                        ? pin_cfg_t'({wdata[CB_DRV], wdata[CB_PULL], wdata[CB_INEN], wdata[CB_MUXEN]})
                        : bulk_cfg;
            sel_wval[p] = mux_byte_hit ? wdata[LANE +: SEL_W]
                                       : wdata[BK_SEL_LSB +: SEL_W];
        end
    end
endmodule

// File: rtl/bpc_pin_store.sv
module bpc_pin_store
    import bpc_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0]              cfg_we,
    input  pin_cfg_t [NUM_PINS-1:0]          cfg_wval,
    input  logic [NUM_PINS-1:0]              sel_we,
    input  logic [NUM_PINS-1:0][SEL_W-1:0]   sel_wval,
    output pin_cfg_t [NUM_PINS-1:0]          cfg_q,
    output logic [NUM_PINS-1:0][SEL_W-1:0]   sel_q
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[p] <= '0;
                sel_q[p] <= '0;
            end else begin
                if (cfg_we[p]) cfg_q[p] <= cfg_wval[p];
                if (sel_we[p]) sel_q[p] <= sel_wval[p];
            end
        end

        // R5: a pin without a configuration write enable holds its flags
        a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we[p] |=> $stable(cfg_q[p]));
        // R5: a pin without a selection write enable holds its selection
        a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_we[p] |=> $stable(sel_q[p]));
    end
endmodule

// File: rtl/bpc_readback.sv
module bpc_readback
    import bpc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 7,
    parameter int BULK_OFS = 'h28,
    parameter int MUX_OFS  = 'h30,
    parameter int CFG_OFS  = 'h40
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  pin_cfg_t [NUM_PINS-1:0]          cfg_q,
    input  logic [NUM_PINS-1:0][SEL_W-1:0]   sel_q,
    output logic [31:0]                      rdata
);
    localparam int NUM_PAIRS = NUM_PINS / 2;

    logic [31:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (addr == ADDR_W'(CFG_OFS + i)) rd_word[7:0] = cfg_to_byte(cfg_q[i]);
        end
        for (int k = 0; k < NUM_PAIRS; k++) begin
            if (addr == ADDR_W'(MUX_OFS + k)) rd_word[7:0] = {sel_q[2*k+1], sel_q[2*k]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_word : '0;
    end

    // R8: the bulk word reads as zero
    a_r8_bulk_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(BULK_OFS)) |=> (rdata == '0));
    // R9: no read request, no read data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

// File: rtl/bulk_pincfg.sv
module bulk_pincfg
    import bpc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 7,
    parameter int BULK_OFS = 'h28,
    parameter int MUX_OFS  = 'h30,
    parameter int CFG_OFS  = 'h40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output logic [NUM_PINS-1:0]        mux_en,
    output logic [NUM_PINS-1:0]        in_en,
    output logic [NUM_PINS-1:0]        pull_en,
    output logic [NUM_PINS-1:0]        drv_str,
    output logic [NUM_PINS*SEL_W-1:0]  mux_sel
);
    localparam int HALF_W = NUM_PINS / 2;

    logic [NUM_PINS-1:0]             cfg_we, sel_we;
    pin_cfg_t [NUM_PINS-1:0]         cfg_wval, cfg_q;
    logic [NUM_PINS-1:0][SEL_W-1:0]  sel_wval, sel_q;

    bpc_decode #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
        .BULK_OFS(BULK_OFS), .MUX_OFS(MUX_OFS), .CFG_OFS(CFG_OFS)
    ) u_decode (
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg_we(cfg_we), .cfg_wval(cfg_wval),
        .sel_we(sel_we), .sel_wval(sel_wval)
    );

    bpc_pin_store #(.NUM_PINS(NUM_PINS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wval(cfg_wval),
        .sel_we(sel_we), .sel_wval(sel_wval),
        .cfg_q(cfg_q), .sel_q(sel_q)
    );

    bpc_readback #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
        .BULK_OFS(BULK_OFS), .MUX_OFS(MUX_OFS), .CFG_OFS(CFG_OFS)
    ) u_readback (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .cfg_q(cfg_q), .sel_q(sel_q), .rdata(rdata)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
        assign mux_en[p]              = cfg_q[p].muxen;
        assign in_en[p]               = cfg_q[p].inen;
        assign pull_en[p]             = cfg_q[p].pull;
        assign drv_str[p]             = cfg_q[p].drv;
        assign mux_sel[p*SEL_W +: SEL_W] = sel_q[p];
    end

    logic bulk_wr;
    assign bulk_wr = wr_en && (addr == ADDR_W'(BULK_OFS));

    // R5: configuration write enable clear keeps every flag
    a_r5_bulk_no_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_wr && !wdata[BK_WR_CFG]) |=> $stable({mux_en, in_en, pull_en, drv_str}));
    // R5: selection write enable clear keeps every selection
    a_r5_bulk_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_wr && !wdata[BK_WR_SEL]) |=> $stable(mux_sel));
    // R3: lower-half bulk write leaves upper half untouched
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_wr && !wdata[BK_HALF]) |=> $stable({mux_en[NUM_PINS-1:HALF_W], in_en[NUM_PINS-1:HALF_W],
                                                 pull_en[NUM_PINS-1:HALF_W], drv_str[NUM_PINS-1:HALF_W],
                                                 mux_sel[NUM_PINS*SEL_W-1:HALF_W*SEL_W]}));
    // R2: pin 0 takes the bulk flags when selected
    a_r2_pin0_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_wr && wdata[BK_WR_CFG] && !wdata[BK_HALF] && wdata[0])
        |=> (mux_en[0] == $past(wdata[BK_MUXEN]) && drv_str[0] == $past(wdata[BK_DRV])));
    // R4: pin 0 takes the bulk selection when selected
    a_r4_pin0_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_wr && wdata[BK_WR_SEL] && !wdata[BK_HALF] && wdata[0])
        |=> (mux_sel[SEL_W-1:0] == $past(wdata[BK_SEL_LSB +: SEL_W])));
endmodule

// File: tb/bulk_pincfg_bench.sv
module bulk_pincfg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [NP-1:0] mux_en, in_en, pull_en, drv_str;
    logic [NP*4-1:0] mux_sel;

    bulk_pincfg u_bulk_pincfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .mux_en(mux_en), .in_en(in_en), .pull_en(pull_en),
        .drv_str(drv_str), .mux_sel(mux_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] v; string tag; } exp_t;
    exp_t q[$];

    logic [7:0] cfg_m [NP];
    logic [3:0] sel_m [NP];

    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= rd_en;

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data when the registered result is due
    always @(negedge clk) begin
        if (rst_n && rd_seen) begin
            if (q.size() == 0) check("R9 unexpected read data", 128'(rdata), 128'hDEAD);
            else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, 128'(rdata), 128'(e.v));
            end
        end
    end

    function automatic logic [31:0] model_read(logic [6:0] a);
        if (a >= 7'h40 && a <= 7'h5F) return {24'h0, cfg_m[a - 7'h40]};
        if (a >= 7'h30 && a <= 7'h3F) return {24'h0, sel_m[2*(a-7'h30)+1], sel_m[2*(a-7'h30)]};
        return 32'h0;
    endfunction

    task automatic model_write(logic [6:0] a, logic [31:0] d);
        if (a == 7'h28) begin
            for (int p = 0; p < NP; p++) begin
                if (d[31] == logic'(p / 16) && d[p % 16]) begin
                    if (d[30]) cfg_m[p] = {1'b0, d[22], 3'b000, d[18], d[17], d[16]};
                    if (d[28]) sel_m[p] = d[27:24];
                end
            end
        end else if (a >= 7'h30 && a <= 7'h3F) begin
            sel_m[2*(a-7'h30)]   = d[3:0];
            sel_m[2*(a-7'h30)+1] = d[7:4];
        end else if (a >= 7'h40 && a <= 7'h5F) begin
            cfg_m[a-7'h40] = d[7:0] & 8'h47;
        end
    endtask

    task automatic bus_wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        model_write(a, d);
    endtask

    task automatic bus_rd(logic [6:0] a, string tag);
        exp_t e;
        @(negedge clk);
        e.v = model_read(a); e.tag = tag;
        q.push_back(e);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_pads(string tag);
        logic [NP-1:0] m, i, pl, dv;
        logic [NP*4-1:0] s;
        for (int p = 0; p < NP; p++) begin
            m[p] = cfg_m[p][0]; i[p] = cfg_m[p][1];
            pl[p] = cfg_m[p][2]; dv[p] = cfg_m[p][6];
            s[p*4 +: 4] = sel_m[p];
        end
        check({tag, " mux_en"},  128'(mux_en),  128'(m));
        check({tag, " in_en"},   128'(in_en),   128'(i));
        check({tag, " pull_en"}, 128'(pull_en), 128'(pl));
        check({tag, " drv_str"}, 128'(drv_str), 128'(dv));
        check({tag, " mux_sel"}, 128'(mux_sel), 128'(s));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++) begin cfg_m[p] = '0; sel_m[p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_pads("R1 reset");
        bus_rd(7'h40, "R1 reset cfg byte pin0");
        bus_rd(7'h3F, "R1 reset mux byte pair15");

        // R2 R4: lower half, mask 0x00A5, flags mux/pull/drive, selection 9
        bus_wr(7'h28, 32'h5945_00A5);
        chk_pads("R2 R4 lower bulk");
        check("R2 pin0 cfg literal", 128'(cfg_m[0]), 128'h45);
        bus_rd(7'h40, "R2 read pin0 cfg");
        bus_rd(7'h30, "R4 read pair0 mux");
        bus_rd(7'h33, "R4 read pair3 mux");

        // R3: upper half, mask 0x8001, input enable only
        bus_wr(7'h28, 32'hC002_8001);
        chk_pads("R3 upper bulk");
        bus_rd(7'h5F, "R3 read pin31 cfg");
        bus_rd(7'h50, "R3 read pin16 cfg");
        bus_rd(7'h40, "R3 lower pin0 kept");

        // R5: all mask bits, all fields, both enables clear
        bus_wr(7'h28, 32'h0F47_FFFF);
        chk_pads("R5 no enables lower");
        bus_wr(7'h28, 32'h8F47_FFFF);
        chk_pads("R5 no enables upper");

        // R5 R4: selection only on pins 16,17
        bus_wr(7'h28, 32'h9C47_0003);
        chk_pads("R5 sel only");
        bus_rd(7'h38, "R4 read pair8 mux");
        bus_rd(7'h50, "R5 pin16 cfg kept");

        // R3: empty mask with enables changes nothing
        bus_wr(7'h28, 32'h5F47_0000);
        chk_pads("R3 empty mask");

        // R6: mux byte write and read back
        bus_wr(7'h31, 32'h0000_003A);
        chk_pads("R6 mux byte");
        check("R6 pin2 sel literal", 128'(mux_sel[11:8]), 128'hA);
        bus_rd(7'h31, "R6 read pair1 mux");

        // R7: configuration byte keeps only bits 0,1,2,6
        bus_wr(7'h45, 32'h0000_00FF);
        chk_pads("R7 cfg byte");
        bus_rd(7'h45, "R7 read pin5 cfg");
        bus_wr(7'h46, 32'h0000_00B8);
        chk_pads("R7 cfg byte unimpl only");
        bus_rd(7'h46, "R7 read pin6 cfg");

        // R8: bulk offset and unmapped offsets read as zero
        bus_rd(7'h28, "R8 read bulk word");
        bus_rd(7'h2C, "R8 read unmapped");
        bus_rd(7'h60, "R8 read beyond map");

        // R9: back-to-back reads each return in the following cycle
        @(negedge clk);
        begin
            exp_t e1, e2;
            e1.v = model_read(7'h45); e1.tag = "R9 back-to-back first";
            e2.v = model_read(7'h31); e2.tag = "R9 back-to-back second";
            q.push_back(e1);
            rd_en = 1'b1; addr = 7'h45;
            @(negedge clk);
            q.push_back(e2);
            addr = 7'h31;
            @(negedge clk);
            rd_en = 1'b0;
        end
        repeat (2) @(negedge clk);
        check("R9 idle rdata zero", 128'(rdata), 128'h0);
        check("R9 all reads answered", 128'(q.size()), 128'h0);
        finish_run();
    end
endmodule